// File: doc/BRIEF.md
# Integer ALU with Condition Codes

A single-cycle 32-bit integer execution unit for a load/store pipeline. Each cycle it takes a 6-bit operation code, a first operand from a register and a second operand that is either a register value or a sign-extended 13-bit immediate. The result comes out combinationally in the same cycle. A four-bit condition-code register (negative, zero, overflow, carry) is kept inside the block and is written on the clock edge when the operation asks for it.

The block supports addition and subtraction, each with or without the stored carry as an extra input. It also provides AND, OR and XOR, each with a plain or a complemented second operand, and logical left, logical right and arithmetic right shifts of the first operand. Any code outside this set gives a zero result, raises an illegal-op flag and leaves the condition codes untouched.

Top module: `int_alu_cc`

## Requirements
- R1: When imm_sel_i is 1 the second operand is imm_i sign-extended from bit 12 to 32 bits; when it is 0 the second operand is rs2_i.
- R2: op3_i codes 0s0000 give rs1 plus operand 2 and 0s0100 give rs1 minus operand 2, both modulo 2^32, where s is op3_i bit 4.
- R3: op3_i codes 0s1000 give rs1 plus operand 2 plus stored C, and 0s1100 give rs1 minus operand 2 minus stored C. C is the value held before the edge.
- R4: op3_i codes 0s0001, 0s0010 and 0s0011 give AND, OR and XOR of rs1 and operand 2. Codes 0s0101, 0s0110 and 0s0111 give the same three functions with operand 2 inverted.
- R5: op3_i 100101 shifts rs1 left logically, 100110 shifts it right logically and 100111 shifts it right arithmetically. The shift distance is operand 2 bits [4:0].
- R6: For arithmetic and logic codes the flags are written at the next rising edge only when op3_i bit 4 is 1; otherwise they keep their value.
- R7: flags_o is {N,Z,V,C} in bits 3..0. After an arithmetic op with bit 4 set, N is result bit 31 and Z is 1 when the result is zero. V is signed two's-complement overflow. C is the carry out for addition and the borrow for subtraction.
- R8: After a logic op with bit 4 set, N and Z follow the result and V and C are 0.
- R9: Shift codes never change flags_o.
- R10: Any other op3_i code drives result_o to 0 and illegal_o to 1, and leaves flags_o unchanged. Legal codes drive illegal_o to 0.
- R11: While rst_ni is low, flags_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op3_i | input | 6 | Operation code |
| imm_sel_i | input | 1 | Selects the immediate as operand 2 |
| rs1_i | input | 32 | First operand |
| rs2_i | input | 32 | Register second operand |
| imm_i | input | 13 | Signed immediate |
| result_o | output | 32 | Combinational result |
| illegal_o | output | 1 | Unsupported op3_i code |
| flags_o | output | 4 | Stored {N,Z,V,C} |

## Verification
The hardest cases to reach are the chained-carry ones. The carry-in variants only differ from the plain ones once C holds a known 1, and the borrow convention only shows when a subtraction with borrow-in crosses zero. The stimulus therefore sets C on purpose first, with an all-ones plus one or a zero minus one, and then issues the carry forms on top of it. It also places shifts and illegal codes right after flag-setting ops, so that a held flag can be told apart from a rewritten one. A long random run over all 64 codes, with operands biased toward 0, all ones and the sign boundary, then covers the other combinations.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;
  typedef enum logic [1:0] {
    CLS_ARITH,
    CLS_LOGIC,
    CLS_SHIFT,
    CLS_ILL
  } op_cls_e;

  typedef enum logic [1:0] {
    LFN_AND = 2'b01,
    LFN_OR  = 2'b10,
    LFN_XOR = 2'b11,
    LFN_NONE = 2'b00
  } logic_fn_e;

  typedef enum logic [1:0] {
    SH_SLL  = 2'b01,
    SH_SRL  = 2'b10,
    SH_SRA  = 2'b11,
    SH_NONE = 2'b00
  } shift_kind_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } cc_t;
endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
  import int_alu_pkg::*;
#(
  parameter int unsigned OP_W = 6
) (
  input  logic [OP_W-1:0] op3_i,
  output op_cls_e         cls_o,
  output logic            use_cin_o,
  output logic            is_sub_o,
  output logic            inv_b_o,
  output logic_fn_e       lfn_o,
  output shift_kind_e     shk_o,
  output logic            flag_we_o
);
  logic fmt_alu;
  assign fmt_alu = (op3_i[OP_W-1] == 1'b0);

  always_comb begin
    cls_o     = CLS_ILL;
    use_cin_o = 1'b0;
    is_sub_o  = 1'b0;
    inv_b_o   = 1'b0;
    lfn_o     = LFN_NONE;
    shk_o     = SH_NONE;
    flag_we_o = 1'b0;
    if (fmt_alu && op3_i[1:0] == 2'b00) begin
      cls_o     = CLS_ARITH;
      use_cin_o = op3_i[3];
      is_sub_o  = op3_i[2];
      flag_we_o = op3_i[4];
    end else if (fmt_alu && !op3_i[3]) begin
      cls_o     = CLS_LOGIC;
      inv_b_o   = op3_i[2];
      lfn_o     = logic_fn_e'(op3_i[1:0]);
      flag_we_o = op3_i[4];
    end else if (op3_i[OP_W-1:2] == 4'b1001 && op3_i[1:0] != 2'b00) begin
      cls_o = CLS_SHIFT;
      shk_o = shift_kind_e'(op3_i[1:0]);
    end
  end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int unsigned W = 32
) (
  input  logic         is_sub_i,
  input  logic         use_cin_i,
  input  logic         cin_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o,
  output logic         cy_o,
  output logic         ovf_o
);
  logic [W-1:0] b_eff;
  logic         c_eff;
  logic [W:0]   sum;

  assign b_eff = is_sub_i ? ~b_i : b_i;
  // a - b - cin == a + ~b + (1 - cin)
  assign c_eff = use_cin_i ? (cin_i ^ is_sub_i) : is_sub_i;
  assign sum   = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
  assign res_o = sum[W-1:0];
  assign cy_o  = is_sub_i ? ~sum[W] : sum[W];
  assign ovf_o = (a_i[W-1] == b_eff[W-1]) && (res_o[W-1] != a_i[W-1]);
endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import int_alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic_fn_e    fn_i,
  input  logic         inv_b_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o
);
  logic [W-1:0] b_eff;
  assign b_eff = inv_b_i ? ~b_i : b_i;

  always_comb begin
    unique case (fn_i)
      LFN_AND: res_o = a_i & b_eff;
      LFN_OR:  res_o = a_i | b_eff;
      LFN_XOR: res_o = a_i ^ b_eff;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/alu_shift.sv
module alu_shift
  import int_alu_pkg::*;
#(
  parameter int unsigned W = 32,
  localparam int unsigned SH_W = $clog2(W)
) (
  input  shift_kind_e     kind_i,
  input  logic [W-1:0]    a_i,
  input  logic [SH_W-1:0] amt_i,
  output logic [W-1:0]    res_o
);
  // Left shift = reverse, right shift with zero fill, reverse back
  logic         left;
  logic         fill;
  logic [W-1:0] a_rev;
  logic [W-1:0] r_rev;
  logic [W-1:0] stage [SH_W+1];

  assign left = (kind_i == SH_SLL);
  assign fill = (kind_i == SH_SRA) & a_i[W-1];

  for (genvar i = 0; i < W; i++) begin : g_rev
    assign a_rev[i] = a_i[W-1-i];
    assign r_rev[i] = stage[SH_W][W-1-i];
  end

  assign stage[0] = left ? a_rev : a_i;

  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    localparam int unsigned D = 1 << k;
    assign stage[k+1] = amt_i[k] ? {{D{fill}}, stage[k][W-1:D]} : stage[k];
  end

  assign res_o = (kind_i == SH_NONE) ? '0 : (left ? r_rev : stage[SH_W]);
endmodule

// File: rtl/int_alu_cc.sv
module int_alu_cc
  import int_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IMM_W  = 13,
  localparam int unsigned OP_W  = 6,
  localparam int unsigned SH_W  = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OP_W-1:0]   op3_i,
  input  logic              imm_sel_i,
  input  logic [DATA_W-1:0] rs1_i,
  input  logic [DATA_W-1:0] rs2_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [DATA_W-1:0] result_o,
  output logic              illegal_o,
  output logic [3:0]        flags_o
);
  op_cls_e     cls;
  logic        use_cin, is_sub, inv_b, flag_we;
  logic_fn_e   lfn;
  shift_kind_e shk;

  logic [DATA_W-1:0] op2;
  logic [DATA_W-1:0] arith_res, logic_res, shift_res;
  logic              arith_cy, arith_ovf;
  cc_t               flags_q, flags_d;

  assign op2 = imm_sel_i ? {{(DATA_W-IMM_W){imm_i[IMM_W-1]}}, imm_i} : rs2_i;

  alu_op_decode #(.OP_W(OP_W)) i_dec (
    .op3_i    (op3_i),
    .cls_o    (cls),
    .use_cin_o(use_cin),
    .is_sub_o (is_sub),
    .inv_b_o  (inv_b),
    .lfn_o    (lfn),
    .shk_o    (shk),
    .flag_we_o(flag_we)
  );

  alu_addsub #(.W(DATA_W)) i_addsub (
    .is_sub_i (is_sub),
    .use_cin_i(use_cin),
    .cin_i    (flags_q.c),
    .a_i      (rs1_i),
    .b_i      (op2),
    .res_o    (arith_res),
    .cy_o     (arith_cy),
    .ovf_o    (arith_ovf)
  );

  alu_logic #(.W(DATA_W)) i_logic (
    .fn_i   (lfn),
    .inv_b_i(inv_b),
    .a_i    (rs1_i),
    .b_i    (op2),
    .res_o  (logic_res)
  );

  alu_shift #(.W(DATA_W)) i_shift (
    .kind_i(shk),
    .a_i   (rs1_i),
    .amt_i (op2[SH_W-1:0]),
    .res_o (shift_res)
  );

  always_comb begin
    unique case (cls)
      CLS_ARITH: result_o = arith_res;
      CLS_LOGIC: result_o = logic_res;
      CLS_SHIFT: result_o = shift_res;
      default:   result_o = '0;
    endcase
  end

  assign illegal_o = (cls == CLS_ILL);

  always_comb begin
    flags_d   = flags_q;
    flags_d.n = result_o[DATA_W-1];
    flags_d.z = (result_o == '0);
    flags_d.v = (cls == CLS_ARITH) ? arith_ovf : 1'b0;
    flags_d.c = (cls == CLS_ARITH) ? arith_cy  : 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flags_q <= '0;
    else if (flag_we) flags_q <= flags_d;
  end

  assign flags_o = flags_q;

  // R9
  shift_flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cls == CLS_SHIFT) |=> $stable(flags_o));
  // R10
  ill_flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> $stable(flags_o));
  // R10
  ill_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (result_o == '0));
  // R6
  no_write_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!op3_i[4] && !illegal_o) |=> $stable(flags_o));
  // R8
  logic_vc_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cls == CLS_LOGIC && op3_i[4]) |=> (flags_o[1:0] == 2'b00));
  // R7
  zero_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op3_i[4] && !illegal_o) |=> (flags_o[2] == ($past(result_o) == '0)));
  // R7
  neg_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op3_i[4] && !illegal_o) |=> (flags_o[3] == $past(result_o[DATA_W-1])));
endmodule

// File: tb/test_int_alu_cc.sv
module test_int_alu_cc;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [5:0]  op3 = '0;
  logic        imm_sel = 1'b0;
  logic [31:0] rs1 = '0, rs2 = '0;
  logic [12:0] imm = '0;
  logic [31:0] result;
  logic        illegal;
  logic [3:0]  flags;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 0;

  logic [3:0] mdl_flags = '0;
  string      ftag = "R11";

  always #10 clk = ~clk;

  int_alu_cc i_int_alu_cc (
    .clk_i(clk), .rst_ni(rst_ni), .op3_i(op3), .imm_sel_i(imm_sel),
    .rs1_i(rs1), .rs2_i(rs2), .imm_i(imm),
    .result_o(result), .illegal_o(illegal), .flags_o(flags)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic void model(input logic [5:0] op, input logic [31:0] a, input logic [31:0] b,
                                input logic [3:0] f, output logic [31:0] r, output logic ill,
                                output logic [3:0] nf, output string tag);
    longint ua, ub, sa, sb, u, s;
    logic   cin, c, v;
    logic [31:0] bb;
    nf = f; ill = 1'b0; r = '0; tag = "R10";
    ua = a; ub = b; sa = $signed(a); sb = $signed(b);
    if (op[5] == 1'b0 && op[1:0] == 2'b00) begin
      cin = op[3] ? f[0] : 1'b0;
      if (!op[2]) begin
        u = ua + ub + cin; s = sa + sb + cin; c = (u > 64'hFFFF_FFFF);
      end else begin
        u = ua - ub - cin; s = sa - sb - cin; c = (ua < ub + cin);
      end
      r = u[31:0];
      v = (s > 64'sd2147483647) || (s < -64'sd2147483648);
      if (op[4]) nf = {r[31], r == 0, v, c};
      tag = op[3] ? "R3" : "R2";
    end else if (op[5] == 1'b0 && op[3] == 1'b0) begin
      bb = op[2] ? ~b : b;
      case (op[1:0])
        2'd1: r = a & bb;
        2'd2: r = a | bb;
        default: r = a ^ bb;
      endcase
      if (op[4]) nf = {r[31], r == 0, 2'b00};
      tag = "R4";
    end else if (op == 6'b100101) begin r = a << b[4:0];            tag = "R5";
    end else if (op == 6'b100110) begin r = a >> b[4:0];            tag = "R5";
    end else if (op == 6'b100111) begin r = $signed(a) >>> b[4:0]; tag = "R5";
    end else ill = 1'b1;
  endfunction

  task automatic step(input logic [5:0] op, input logic isel, input logic [31:0] a,
                      input logic [31:0] b, input logic [12:0] im);
    logic [31:0] b2, r;
    logic        ill;
    logic [3:0]  nf;
    string       tag;
    @(negedge clk);
    op3 = op; imm_sel = isel; rs1 = a; rs2 = b; imm = im;
    #1;
    b2 = isel ? {{19{im[12]}}, im} : b;
    model(op, a, b2, mdl_flags, r, ill, nf, tag);
    chk(result === r, (isel && !ill) ? "R1" : tag, result, r);
    chk(illegal === ill, "R10", {31'b0, illegal}, {31'b0, ill});
    chk(flags === mdl_flags, ftag, {28'b0, flags}, {28'b0, mdl_flags});
    @(posedge clk); #1;
    mdl_flags = nf;
    if (ill) ftag = "R10";
    else if (op[5]) ftag = "R9";
    else if (!op[4]) ftag = "R6";
    else if (tag == "R4") ftag = "R8";
    else ftag = "R7";
  endtask

  function automatic logic [31:0] pick();
    case ($urandom_range(0, 5))
      0: return 32'h0;
      1: return 32'hFFFF_FFFF;
      2: return 32'h7FFF_FFFF;
      3: return 32'h8000_0000;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11
    chk(flags === 4'h0, "R11", {28'b0, flags}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(flags === 4'h0, "R11", {28'b0, flags}, 32'h0);

    // R1: negative immediate, positive immediate, register path
    step(6'b000000, 1'b1, 32'd100, 32'hDEAD, 13'h1FFF);
    step(6'b000000, 1'b1, 32'd100, 32'hDEAD, 13'h0FFF);
    step(6'b000000, 1'b0, 32'd100, 32'd23, 13'h1000);
    // R2/R7: carry out with zero result, then borrow, then overflow
    step(6'b010000, 1'b0, 32'hFFFF_FFFF, 32'd1, 13'h0);
    // R3: add with stored carry = 1
    step(6'b001000, 1'b0, 32'd1, 32'd1, 13'h0);
    step(6'b010100, 1'b0, 32'd0, 32'd1, 13'h0);
    // R3: subtract with stored borrow crossing zero
    step(6'b011100, 1'b0, 32'd1, 32'd1, 13'h0);
    step(6'b010000, 1'b0, 32'h7FFF_FFFF, 32'd1, 13'h0);
    step(6'b010100, 1'b0, 32'h8000_0000, 32'd1, 13'h0);
    // R9: shifts after flags set, distance from low 5 bits
    step(6'b100101, 1'b0, 32'h8000_0001, 32'd33, 13'h0);
    step(6'b100110, 1'b0, 32'h8000_0000, 32'd31, 13'h0);
    step(6'b100111, 1'b0, 32'h8000_0000, 32'd4, 13'h0);
    step(6'b100111, 1'b1, 32'h4000_0000, 32'd0, 13'h1FFF);
    // R4/R8: six logic functions, flag forms clear V and C
    step(6'b010000, 1'b0, 32'h7FFF_FFFF, 32'd1, 13'h0);
    step(6'b010001, 1'b0, 32'hF0F0_F0F0, 32'hFF00_FF00, 13'h0);
    step(6'b010010, 1'b0, 32'h0, 32'h0, 13'h0);
    step(6'b000011, 1'b0, 32'hAAAA_AAAA, 32'hFFFF_0000, 13'h0);
    step(6'b010101, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 13'h0);
    step(6'b000110, 1'b0, 32'h1234_0000, 32'hFFFF_FF00, 13'h0);
    step(6'b010111, 1'b0, 32'h5555_5555, 32'hAAAA_AAAA, 13'h0);
    // R6: no flag write with s=0
    step(6'b010000, 1'b0, 32'hFFFF_FFFF, 32'd1, 13'h0);
    step(6'b000100, 1'b0, 32'd0, 32'd5, 13'h0);
    // R10: illegal codes after flags set
    step(6'b011001, 1'b0, 32'd5, 32'd5, 13'h0);
    step(6'b101000, 1'b0, 32'd5, 32'd5, 13'h0);
    step(6'b100100, 1'b0, 32'd5, 32'd5, 13'h0);
    step(6'b111111, 1'b0, 32'd5, 32'd5, 13'h0);
    // random sweep over all codes
    for (int i = 0; i < 4000; i++)
      step(6'($urandom), 1'($urandom), pick(), pick(), 13'($urandom));
    step(6'b111111, 1'b0, 32'd0, 32'd0, 13'h0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule